// File: doc/BRIEF.md
# Spatial Random Dither for 12-bit RGB Pixels

This block narrows a stream of 12-bit red, green and blue components to either 6 or 8 significant bits per component. Before the low bits are dropped, a pseudo-random value is added underneath the kept bits, so the rounding error is scattered across the picture instead of showing up as banding. Each colour channel owns a 28-bit linear feedback shift register that is loaded from its own seed and steps once per accepted pixel.

The register polynomial is either common to all three channels or different per channel. The registers can be reloaded at the start of every frame. In that case the seed is mixed with a bit-reversed frame count so that consecutive frames get different noise. An optional high-pass step XORs each random sample with the previous one, and a mode bit inverts the noise. Pixels arrive with a valid strobe and start-of-frame and end-of-line markers. Results leave one clock later with the markers delayed to match. When the block is disabled, or the depth code is not supported, the pixels pass through unchanged.

Top module: `pix_spatial_dither`

## Requirements
- R1: With depth code 0, each output component keeps its upper 6 bits and has bits 5:0 equal to zero. The noise is the top 6 bits (27:22) of the channel's current LFSR state.
- R2: With depth code 1, each output component keeps its upper 8 bits and has bits 3:0 equal to zero. The noise is the top 4 bits (27:24) of the current LFSR state.
- R3: With the enable low, or with depth code 2 or 3, each output component equals its input component exactly.
- R4: The noise is added to the 12-bit input. A sum above 0xFFF saturates to 0xFFF before truncation, so a dithered output is never below the truncated input.
- R5: With the polynomial-select input low, every channel uses x^28 + x^3 + 1. Each step shifts the state left by one, and the new bit 0 is bit 27 XOR bit 2. Each channel loads from its own seed and steps once per valid pixel while dithering is active.
- R6: With the polynomial-select input high, red keeps tap bit 2 (x^3), green uses tap bit 8 (x^9) and blue uses tap bit 12 (x^13).
- R7: The first valid pixel after reset, or after dithering becomes active, uses the loaded seed value as its state. With frame-random off, later start-of-frame pixels do not reload.
- R8: With frame-random on, every valid start-of-frame pixel reloads each register with its seed XOR (4-bit frame count, bit-reversed, placed in bits 27:24). The count starts at 0, advances on every such pixel, wraps from 15 to 0, and clears while frame-random is off or dithering is inactive.
- R9: With high-pass on, the noise used is the raw sample XOR the channel's previous raw sample. On a reload pixel the previous sample counts as zero.
- R10: With mode bit 1, the noise is bitwise inverted within its width before the add. With mode bit 0, it is used as drawn.
- R11: out_valid follows in_valid one cycle later. out_sof and out_eol follow the markers of a valid input pixel one cycle later.
- R12: During reset, out_valid, out_sof, out_eol and all output components are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Dither enable |
| cfg_depth | input | 2 | 0: 6 bits, 1: 8 bits, 2/3: pass-through |
| cfg_mode | input | 1 | 1 inverts the noise |
| cfg_chan_poly | input | 1 | 1 selects per-channel polynomials |
| cfg_frame_rand | input | 1 | Reload registers at every frame start |
| cfg_highpass | input | 1 | XOR noise with previous sample |
| seed_r | input | 28 | Red seed |
| seed_g | input | 28 | Green seed |
| seed_b | input | 28 | Blue seed |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Start of frame marker |
| in_eol | input | 1 | End of line marker |
| in_r | input | 12 | Red component in |
| in_g | input | 12 | Green component in |
| in_b | input | 12 | Blue component in |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Delayed start of frame |
| out_eol | output | 1 | Delayed end of line |
| out_r | output | 12 | Red component out |
| out_g | output | 12 | Green component out |
| out_b | output | 12 | Blue component out |

## Verification
The assertions watch the properties that hold on every cycle regardless of the noise. These are the one-cycle alignment of valid and markers, the zeroed low bits at each depth, exact pass-through when inactive, and the rule that dithering never lowers a component below its truncated input. The exact noise sequences cannot be seen by a single-cycle property. This covers the shared and per-channel taps, loading once versus reloading per frame, the bit-reversed frame count, high-pass and inversion. The bench's scenarios show these by replaying streams against an independent model of the registers.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int PIX_W    = 12;
  localparam int LFSR_W   = 28;
  localparam int BASE_TAP = 3;
  localparam int DROP_W   = $clog2(PIX_W + 1);
  localparam int NCHAN    = 3;

  // feedback tap exponent used by a channel when per-channel polynomials are on
  function automatic int chan_tap(int idx);
    case (idx)
      0:       return 3;
      1:       return 9;
      default: return 13;
    endcase
  endfunction

  // one step of x^LFSR_W + x^tap + 1, shift toward the MSB
  function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s, int tap);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[tap-1]};
  endfunction

  // add noise, clip at all-ones, clear the dropped bits
  function automatic logic [PIX_W-1:0] sat_trunc(logic [PIX_W-1:0] pix,
                                                 logic [PIX_W-1:0] rnd,
                                                 logic [DROP_W-1:0] drop);
    logic [PIX_W:0]   sum;
    logic [PIX_W-1:0] clipped;
    logic [PIX_W-1:0] keep;
    sum     = {1'b0, pix} + {1'b0, rnd};
    clipped = sum[PIX_W] ? '1 : sum[PIX_W-1:0];
    keep    = ~PIX_W'((PIX_W'(1) << drop) - PIX_W'(1));
    return clipped & keep;
  endfunction
endpackage

// File: rtl/dith_chan.sv
module dith_chan
  import dith_pkg::*;
#(
  parameter int ALT_TAP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed_val,
  input  logic              alt_poly,
  input  logic              hp_en,
  input  logic              invert,
  input  logic [DROP_W-1:0] drop,
  input  logic [PIX_W-1:0]  pix_in,
  output logic [PIX_W-1:0]  pix_out
);
  logic [LFSR_W-1:0] state_q, cur_state, next_state;
  logic [PIX_W-1:0]  prev_q, raw_rnd, prev_eff, used_rnd, inv_mask;

  always_comb begin
    cur_state  = load ? seed_val : state_q;
    next_state = lfsr_step(cur_state, alt_poly ? ALT_TAP : BASE_TAP);
    raw_rnd    = PIX_W'(cur_state >> (LFSR_W - int'(drop)));
    prev_eff   = load ? '0 : prev_q;
    inv_mask   = PIX_W'((PIX_W'(1) << drop) - PIX_W'(1));
    used_rnd   = hp_en ? (raw_rnd ^ prev_eff) : raw_rnd;
    if (invert) used_rnd = used_rnd ^ inv_mask;
    pix_out    = sat_trunc(pix_in, used_rnd, drop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      prev_q  <= '0;
    end else if (adv) begin
      state_q <= next_state;
      prev_q  <= raw_rnd;
    end
  end
endmodule

// File: rtl/pix_spatial_dither.sv
module pix_spatial_dither
  import dith_pkg::*;
#(
  parameter int NARROW_W  = 6,
  parameter int WIDE_W    = 8,
  parameter int FRAME_MAX = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic [1:0]           cfg_depth,
  input  logic                 cfg_mode,
  input  logic                 cfg_chan_poly,
  input  logic                 cfg_frame_rand,
  input  logic                 cfg_highpass,
  input  logic [LFSR_W-1:0]    seed_r,
  input  logic [LFSR_W-1:0]    seed_g,
  input  logic [LFSR_W-1:0]    seed_b,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eol,
  input  logic [PIX_W-1:0]     in_r,
  input  logic [PIX_W-1:0]     in_g,
  input  logic [PIX_W-1:0]     in_b,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic                 out_eol,
  output logic [PIX_W-1:0]     out_r,
  output logic [PIX_W-1:0]     out_g,
  output logic [PIX_W-1:0]     out_b
);
  localparam int CNT_W = $clog2(FRAME_MAX + 1);

  // named internal events
  logic              active, sof_px, load_now, step_now;
  logic              pend_q;
  logic [CNT_W-1:0]  cnt_q, cnt_rev;
  logic [LFSR_W-1:0] frame_mix;
  logic [DROP_W-1:0] drop;
  logic [LFSR_W-1:0] seed_a  [NCHAN];
  logic [PIX_W-1:0]  pix_in_a  [NCHAN];
  logic [PIX_W-1:0]  pix_out_a [NCHAN];

  assign active   = cfg_en && (cfg_depth == 2'd0 || cfg_depth == 2'd1);
  assign sof_px   = in_valid && in_sof;
  assign load_now = active && in_valid && (pend_q || (cfg_frame_rand && in_sof));
  assign step_now = active && in_valid;
  assign drop     = (cfg_depth == 2'd0) ? DROP_W'(PIX_W - NARROW_W) : DROP_W'(PIX_W - WIDE_W);

  assign seed_a[0]   = seed_r;
  assign seed_a[1]   = seed_g;
  assign seed_a[2]   = seed_b;
  assign pix_in_a[0] = in_r;
  assign pix_in_a[1] = in_g;
  assign pix_in_a[2] = in_b;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) cnt_rev[i] = cnt_q[CNT_W-1-i];
    frame_mix = LFSR_W'(cnt_rev) << (LFSR_W - CNT_W);
  end

  // seed load pending from reset or inactivity until the first active pixel
  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b1;
    else if (!active)  pend_q <= 1'b1;
    else if (in_valid) pend_q <= 1'b0;
  end

  // frame counter, runs only while frame-random dithering is active
  always_ff @(posedge clk) begin
    if (!rst_n || !(active && cfg_frame_rand)) cnt_q <= '0;
    else if (sof_px) cnt_q <= (cnt_q == CNT_W'(FRAME_MAX)) ? '0 : cnt_q + 1'b1;
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    dith_chan #(.ALT_TAP(chan_tap(c))) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (step_now),
      .load     (load_now),
      .seed_val (seed_a[c] ^ frame_mix),
      .alt_poly (cfg_chan_poly),
      .hp_en    (cfg_highpass),
      .invert   (cfg_mode),
      .drop     (drop),
      .pix_in   (pix_in_a[c]),
      .pix_out  (pix_out_a[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= sof_px;
      out_eol   <= in_valid && in_eol;
      if (in_valid) begin
        out_r <= active ? pix_out_a[0] : in_r;
        out_g <= active ? pix_out_a[1] : in_g;
        out_b <= active ? pix_out_a[2] : in_b;
      end
    end
  end
endmodule

// File: rtl/dith_checker.sv
module dith_checker
  import dith_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic [1:0]       cfg_depth,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eol,
  input logic [PIX_W-1:0] in_r,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eol,
  input logic [PIX_W-1:0] out_r
);
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  p_markers_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_sof == $past(in_valid && in_sof)) && (out_eol == $past(in_valid && in_eol)));

  p_narrow_lsb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rst_n) && $past(cfg_en) && $past(cfg_depth) == 2'd0) |-> (out_r[5:0] == 6'd0));

  p_wide_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rst_n) && $past(cfg_en) && $past(cfg_depth) == 2'd1) |-> (out_r[3:0] == 4'd0));

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rst_n) && (!$past(cfg_en) || $past(cfg_depth) >= 2'd2)) |-> (out_r == $past(in_r)));

  p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rst_n) && $past(cfg_en) && $past(cfg_depth) == 2'd0) |-> (out_r >= ($past(in_r) & 12'hFC0)));
endmodule

bind pix_spatial_dither dith_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .cfg_depth (cfg_depth),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_eol    (in_eol),
  .in_r      (in_r),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_eol   (out_eol),
  .out_r     (out_r)
);

// File: tb/pix_spatial_dither_tb_top.sv
`timescale 1ns/1ps
module pix_spatial_dither_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 0, cfg_mode = 0, cfg_chan_poly = 0, cfg_frame_rand = 0, cfg_highpass = 0;
  logic [1:0] cfg_depth = 0;
  logic [27:0] seed_r = 0, seed_g = 0, seed_b = 0;
  logic in_valid = 0, in_sof = 0, in_eol = 0;
  logic [11:0] in_r = 0, in_g = 0, in_b = 0;
  logic out_valid, out_sof, out_eol;
  logic [11:0] out_r, out_g, out_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pix_spatial_dither dut_i (.*);

  // en[55] depth[54:53] mode[52] in[51:40] seed[39:12] expected[11:0]
  localparam logic [55:0] VEC [9] = '{
    {1'b1, 2'd0, 1'b0, 12'h123, 28'hA000000, 12'h140},
    {1'b1, 2'd1, 1'b0, 12'h123, 28'hA000000, 12'h120},
    {1'b1, 2'd0, 1'b0, 12'hFF0, 28'hFFFFFFF, 12'hFC0},
    {1'b1, 2'd1, 1'b1, 12'h0F7, 28'h0000000, 12'h100},
    {1'b0, 2'd0, 1'b0, 12'h5A5, 28'hA000000, 12'h5A5},
    {1'b1, 2'd2, 1'b0, 12'hABC, 28'hFFFFFFF, 12'hABC},
    {1'b1, 2'd3, 1'b0, 12'h001, 28'hFFFFFFF, 12'h001},
    {1'b1, 2'd0, 1'b0, 12'h03F, 28'h0000001, 12'h000},
    {1'b1, 2'd0, 1'b1, 12'h001, 28'hFFFFFFF, 12'h000}
  };

  // independent reference state
  logic [27:0] m_st [3];
  logic [11:0] m_prev [3];
  bit          m_pend;
  int          m_cnt;
  logic [11:0] e_pix [3];

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] m_step(logic [27:0] s, int t);
    logic fb;
    fb = s[27] ^ s[t-1];
    return (s << 1) | 28'(fb);
  endfunction

  task automatic model(bit sof, logic [11:0] p0, logic [11:0] p1, logic [11:0] p2);
    logic [11:0] pin [3];
    logic [27:0] sd [3];
    int taps [3];
    bit act, ld;
    int drop;
    pin[0] = p0; pin[1] = p1; pin[2] = p2;
    sd[0] = seed_r; sd[1] = seed_g; sd[2] = seed_b;
    taps[0] = 3; taps[1] = cfg_chan_poly ? 9 : 3; taps[2] = cfg_chan_poly ? 13 : 3;
    act = cfg_en && cfg_depth < 2;
    if (!act) begin
      for (int c = 0; c < 3; c++) e_pix[c] = pin[c];
      m_pend = 1; m_cnt = 0;
      return;
    end
    ld = m_pend || (cfg_frame_rand && sof);
    drop = (cfg_depth == 0) ? 6 : 4;
    for (int c = 0; c < 3; c++) begin
      logic [27:0] cur;
      logic [3:0] rv;
      int raw, u, s;
      rv = {m_cnt[0], m_cnt[1], m_cnt[2], m_cnt[3]};
      cur = ld ? (sd[c] ^ {rv, 24'h0}) : m_st[c];
      raw = int'(cur >> (28 - drop));
      u = cfg_highpass ? (raw ^ (ld ? 0 : int'(m_prev[c]))) : raw;
      if (cfg_mode) u = u ^ ((1 << drop) - 1);
      s = int'(pin[c]) + u;
      if (s > 4095) s = 4095;
      e_pix[c] = 12'(s & ~((1 << drop) - 1));
      m_prev[c] = 12'(raw);
      m_st[c] = m_step(cur, taps[c]);
    end
    m_pend = 0;
    if (cfg_frame_rand && sof) m_cnt = (m_cnt == 15) ? 0 : m_cnt + 1;
  endtask

  // called at a falling edge; leaves time at the next falling edge
  task automatic drive_px(string tag, bit sof, bit eol, logic [11:0] p0, logic [11:0] p1, logic [11:0] p2);
    in_valid = 1; in_sof = sof; in_eol = eol; in_r = p0; in_g = p1; in_b = p2;
    model(sof, p0, p1, p2);
    @(negedge clk);
    chk({tag, " R11 valid"}, 12'(out_valid), 12'd1);
    chk({tag, " R11 sof"}, 12'(out_sof), 12'(sof));
    chk({tag, " R11 eol"}, 12'(out_eol), 12'(eol));
    chk({tag, " red"}, out_r, e_pix[0]);
    chk({tag, " green"}, out_g, e_pix[1]);
    chk({tag, " blue"}, out_b, e_pix[2]);
  endtask

  task automatic go_idle();
    in_valid = 0; in_sof = 0; in_eol = 0; cfg_en = 0;
    m_pend = 1; m_cnt = 0;
    @(negedge clk);
  endtask

  task automatic stream(string tag, int npix, int line_len, bit sof_first);
    for (int i = 0; i < npix; i++) begin
      logic [11:0] v;
      v = 12'((i * 389 + 77) % 4096);
      drive_px(tag, sof_first && (i % line_len == 0) && (i % (line_len * 2) == 0),
               (i % line_len) == line_len - 1, v, 12'(v ^ 12'h5C3), 12'(4095 - v));
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    in_valid = 1; in_r = 12'hFFF;
    @(negedge clk);
    // R12: outputs held at zero during reset
    chk("R12 reset valid", 12'(out_valid), 12'd0);
    chk("R12 reset sof", 12'(out_sof), 12'd0);
    chk("R12 reset red", out_r, 12'd0);
    chk("R12 reset green", out_g, 12'd0);
    in_valid = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 idle valid", 12'(out_valid), 12'd0);

    // table walk: each vector is the first pixel after a fresh load (R1 R2 R3 R4 R7 R10)
    for (int k = 0; k < 9; k++) begin
      logic [55:0] v;
      v = VEC[k];
      go_idle();
      cfg_en = v[55]; cfg_depth = v[54:53]; cfg_mode = v[52];
      cfg_chan_poly = 0; cfg_frame_rand = 0; cfg_highpass = 0;
      seed_r = v[39:12]; seed_g = v[39:12]; seed_b = v[39:12];
      in_valid = 1; in_sof = 0; in_eol = 0;
      in_r = v[51:40]; in_g = v[51:40]; in_b = v[51:40];
      @(negedge clk);
      chk($sformatf("R1 R2 R3 R4 R10 vec%0d red", k), out_r, v[11:0]);
      chk($sformatf("R4 vec%0d green", k), out_g, v[11:0]);
      chk($sformatf("R4 vec%0d blue", k), out_b, v[11:0]);
    end

    // R5 R7: shared polynomial, distinct seeds, sof without reload
    go_idle();
    cfg_en = 1; cfg_depth = 0; cfg_mode = 0; cfg_chan_poly = 0; cfg_frame_rand = 0; cfg_highpass = 0;
    seed_r = 28'h9E3779B; seed_g = 28'h1234567; seed_b = 28'hBADC0DE;
    stream("R5 R7 shared", 40, 8, 1);

    // R6: per-channel polynomials, same seed
    go_idle();
    cfg_en = 1; cfg_depth = 1; cfg_chan_poly = 1;
    seed_r = 28'h0000801; seed_g = 28'h0000801; seed_b = 28'h0000801;
    stream("R6 perchan", 48, 12, 0);

    // R8: frame reload with bit-reversed counter, more than 16 frames to see wrap
    go_idle();
    cfg_en = 1; cfg_depth = 0; cfg_chan_poly = 0; cfg_frame_rand = 1;
    seed_r = 28'h5555555; seed_g = 28'h0F0F0F0; seed_b = 28'h3C3C3C3;
    for (int f = 0; f < 18; f++) begin
      drive_px("R8 frame start", 1, 0, 12'h400, 12'h7FF, 12'h001);
      drive_px("R8 mid", 0, 0, 12'h123, 12'h456, 12'h789);
      drive_px("R8 end", 0, 1, 12'hABC, 12'hDEF, 12'h010);
    end

    // R9 R10: high-pass with inversion, depth 1
    go_idle();
    cfg_en = 1; cfg_depth = 1; cfg_frame_rand = 0; cfg_highpass = 1; cfg_mode = 1;
    seed_r = 28'hFEDCBA9; seed_g = 28'h7654321; seed_b = 28'h0ACE135;
    stream("R9 highpass", 32, 8, 1);
    cfg_mode = 0;
    stream("R9 highpass noinv", 16, 8, 0);

    // R3: dropping to pass-through mid-stream
    cfg_depth = 2;
    stream("R3 passthru", 6, 3, 1);

    in_valid = 0;
    @(negedge clk);
    chk("R11 drain valid", 12'(out_valid), 12'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule